// File: doc/BRIEF.md
# Pin Function Select Controller

This block is the routing controller for one bank of pins. For each pin it decides who drives the pad. The pin can be driven by the general-purpose I/O logic of the bank, or by one of four internal peripheral functions, lettered A to D. Software configures it over a small register bus. Most controls come as a pair of mask registers. A 1 written to the "set" register turns the control on for that pin. A 1 written to the "clear" register turns it off. A 0 written to either register leaves that pin alone. A separate read-only status word shows the current state of each control.

The peripheral function of a pin is a two-bit code. Bit 0 of the code comes from one select register and bit 1 from another. Both select registers are plain read/write words. The block also holds, for each pin:
- output enable,
- output data,
- pull-up and pull-down,
- open-drain mode.

It returns the synchronised pad levels, whoever owns the pin. The pad controls it drives are registered.

A global pin number p maps to bank p/32 and to bit p%32 inside that bank. Bit i of every mask and status word refers to pin i.

Top module: `pin_route_ctrl`

## Requirements
- R1: After a synchronous reset, every pin is in the following state. Owner status reads all ones. Direction status, data status, pull-down status and open-drain status read 0. Pull-up status reads all ones. Both select registers read 0. The pad outputs are pad_oe=0, pad_out=0, pad_pu all ones and pad_pd=0.
- R2: Ownership is set by writing a mask to address 0, which gives the marked pins to the I/O logic. It is cleared by writing a mask to address 1, which gives the marked pins to a peripheral. Address 2 reads the owner status, with 1 meaning the pin is under I/O logic.
- R3: For a pin under peripheral control, a code is formed: bit 0 from the select register at address 19 and bit 1 from the select register at address 20. Code 0 means A, 1 means B, 2 means C and 3 means D. The pad takes periph_do and periph_oe at bit code*NPINS+pin. Both select registers read back what was written.
- R4: Writing a mask to address 3 sets the output enable of the marked pins. Writing a mask to address 4 clears it. Address 5 reads the output enable state. For a pin under I/O logic, pad_oe follows this state.
- R5: Output data can only be changed through address 6, which sets bits, and address 7, which clears bits. Address 8 reads the data state. A 0 bit in the written mask leaves that pin unchanged. For a pin under I/O logic, pad_out follows the data state.
- R6: Address 9 returns pad_in after a two-stage synchroniser. This holds whether a pin is owned by the I/O logic or by a peripheral.
- R7: Pull-ups are set at address 10, cleared at address 11 and read at address 12. Pull-downs are set at address 13, cleared at address 14 and read at address 15. Setting a pull-down on a pin clears its pull-up in the same write, and setting a pull-up clears its pull-down. pad_pu and pad_pd are never both 1 on the same pin.
- R8: Open-drain mode is set at address 16, cleared at address 17 and read at address 18. A pin in open-drain mode has pad_out=0 and drives pad_oe only when its source wants to drive a 0. The source is either the I/O logic or the selected peripheral.
- R9: Writes to the read-only addresses 2, 5, 8, 9, 12, 15 and 18 change nothing. Writes to the unmapped addresses 21 to 31 also change nothing. Reads of the unmapped addresses return 0.
- R10: A write changes the register state at the clock edge where it is sampled. A read issued in the following cycle returns the new value. bus_rdata is registered and valid in the cycle after bus_rd. The pad outputs change one clock after the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | DW | Write data / pin mask |
| bus_rdata | output | DW | Registered read data |
| pad_in | input | NPINS | Raw pad levels |
| periph_do | input | 4*NPINS | Peripheral output data, function-major |
| periph_oe | input | 4*NPINS | Peripheral output enables, function-major |
| pad_out | output | NPINS | Registered pad output level |
| pad_oe | output | NPINS | Registered pad output enable |
| pad_pu | output | NPINS | Registered pull-up enable |
| pad_pd | output | NPINS | Registered pull-down enable |

## Verification
Only one bus access occurs per cycle. The two effects that coincide are therefore the two halves of a single pull write. A pull-down set on a pin whose pull-up is on must clear that pull-up at the same edge. The same applies with the roles of pull-up and pull-down swapped. The bench provokes this by writing pull-down masks that overlap pins with active pull-ups, and then pull-up masks that overlap active pull-downs. It judges both status words read back the next cycle and the registered pad pulls one cycle later, against a reference model in which the two updates never leave both pulls set.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int REG_AW = 5;
  localparam int SEL_W  = 2;
  localparam int NFUNC  = 1 << SEL_W;

  localparam logic [REG_AW-1:0] RA_OWN_SET  = 5'd0;
  localparam logic [REG_AW-1:0] RA_OWN_CLR  = 5'd1;
  localparam logic [REG_AW-1:0] RA_OWN_STAT = 5'd2;
  localparam logic [REG_AW-1:0] RA_DIR_SET  = 5'd3;
  localparam logic [REG_AW-1:0] RA_DIR_CLR  = 5'd4;
  localparam logic [REG_AW-1:0] RA_DIR_STAT = 5'd5;
  localparam logic [REG_AW-1:0] RA_DAT_SET  = 5'd6;
  localparam logic [REG_AW-1:0] RA_DAT_CLR  = 5'd7;
  localparam logic [REG_AW-1:0] RA_DAT_STAT = 5'd8;
  localparam logic [REG_AW-1:0] RA_LEVEL    = 5'd9;
  localparam logic [REG_AW-1:0] RA_PU_SET   = 5'd10;
  localparam logic [REG_AW-1:0] RA_PU_CLR   = 5'd11;
  localparam logic [REG_AW-1:0] RA_PU_STAT  = 5'd12;
  localparam logic [REG_AW-1:0] RA_PD_SET   = 5'd13;
  localparam logic [REG_AW-1:0] RA_PD_CLR   = 5'd14;
  localparam logic [REG_AW-1:0] RA_PD_STAT  = 5'd15;
  localparam logic [REG_AW-1:0] RA_OD_SET   = 5'd16;
  localparam logic [REG_AW-1:0] RA_OD_CLR   = 5'd17;
  localparam logic [REG_AW-1:0] RA_OD_STAT  = 5'd18;
  localparam logic [REG_AW-1:0] RA_SEL_LO   = 5'd19;
  localparam logic [REG_AW-1:0] RA_SEL_HI   = 5'd20;
endpackage

// File: rtl/pr_setclr_reg.sv
module pr_setclr_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_m,
  input  logic [W-1:0] clr_m,
  output logic [W-1:0] q
);
  // Set has priority over clear so a plain write (clr all, set data) loads data.
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= (q & ~clr_m) | set_m;
  end
endmodule

// File: rtl/pr_level_sync.sv
module pr_level_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pr_route_mux.sv
module pr_route_mux #(
  parameter int N  = 32,
  parameter int NF = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  own,
  input  logic [N-1:0]  dir,
  input  logic [N-1:0]  dat,
  input  logic [N-1:0]  od,
  input  logic [N-1:0]  pu,
  input  logic [N-1:0]  pd,
  input  logic [N-1:0]  sel_lo,
  input  logic [N-1:0]  sel_hi,
  input  logic [NF*N-1:0] pdo,
  input  logic [NF*N-1:0] poe,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_oe,
  output logic [N-1:0]  pad_pu,
  output logic [N-1:0]  pad_pd
);
  logic [N-1:0] nxt_out, nxt_oe;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [SW-1:0] code;
    logic [NF-1:0] f_do, f_oe;
    logic          src_do, src_oe;

    assign code = {sel_hi[i], sel_lo[i]};

    for (genvar f = 0; f < NF; f++) begin : g_fn
      assign f_do[f] = pdo[f*N + i];
      assign f_oe[f] = poe[f*N + i];
    end

    assign src_do = own[i] ? dat[i] : f_do[code];
    assign src_oe = own[i] ? dir[i] : f_oe[code];

    // Open drain: never drive high, only enable the driver for a low.
    assign nxt_out[i] = od[i] ? 1'b0 : src_do;
    assign nxt_oe[i]  = od[i] ? (src_oe & ~src_do) : src_oe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_pu  <= '1;
      pad_pd  <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
      pad_pu  <= pu;
      pad_pd  <= pd;
    end
  end
endmodule

// File: rtl/pr_bus_read.sv
module pr_bus_read
  import pr_pkg::*;
#(
  parameter int N  = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic [N-1:0]      own,
  input  logic [N-1:0]      dir,
  input  logic [N-1:0]      dat,
  input  logic [N-1:0]      lvl,
  input  logic [N-1:0]      pu,
  input  logic [N-1:0]      pd,
  input  logic [N-1:0]      od,
  input  logic [N-1:0]      sel_lo,
  input  logic [N-1:0]      sel_hi,
  output logic [DW-1:0]     rdata
);
  logic [N-1:0]  pick;
  logic [DW-1:0] nxt;

  always_comb begin
    pick = '0;
    case (addr)
      RA_OWN_STAT: pick = own;
      RA_DIR_STAT: pick = dir;
      RA_DAT_STAT: pick = dat;
      RA_LEVEL:    pick = lvl;
      RA_PU_STAT:  pick = pu;
      RA_PD_STAT:  pick = pd;
      RA_OD_STAT:  pick = od;
      RA_SEL_LO:   pick = sel_lo;
      RA_SEL_HI:   pick = sel_hi;
      default:     pick = '0;
    endcase
    nxt = '0;
    nxt[N-1:0] = pick;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= nxt;
  end
endmodule

// File: rtl/pin_route_ctrl.sv
module pin_route_ctrl
  import pr_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_AW-1:0]     bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic [NPINS-1:0]      pad_in,
  input  logic [NFUNC*NPINS-1:0] periph_do,
  input  logic [NFUNC*NPINS-1:0] periph_oe,
  output logic [NPINS-1:0]      pad_out,
  output logic [NPINS-1:0]      pad_oe,
  output logic [NPINS-1:0]      pad_pu,
  output logic [NPINS-1:0]      pad_pd
);
  localparam int SYNC_STAGES = 2;

  logic [NPINS-1:0] wmask;
  logic [NPINS-1:0] own_s, own_c, dir_s, dir_c, dat_s, dat_c;
  logic [NPINS-1:0] pu_s, pu_c, pd_s, pd_c, od_s, od_c;
  logic [NPINS-1:0] sl_s, sl_c, sh_s, sh_c;
  logic [NPINS-1:0] own_q, dir_q, dat_q, pu_q, pd_q, od_q, sl_q, sh_q;
  logic [NPINS-1:0] lvl_q;

  assign wmask = bus_wdata[NPINS-1:0];

  // Write decode: each address drives one set or clear mask.
  always_comb begin
    own_s = '0; own_c = '0; dir_s = '0; dir_c = '0;
    dat_s = '0; dat_c = '0; pu_s  = '0; pu_c  = '0;
    pd_s  = '0; pd_c  = '0; od_s  = '0; od_c  = '0;
    sl_s  = '0; sl_c  = '0; sh_s  = '0; sh_c  = '0;
    if (bus_wr) begin
      case (bus_addr)
        RA_OWN_SET: own_s = wmask;
        RA_OWN_CLR: own_c = wmask;
        RA_DIR_SET: dir_s = wmask;
        RA_DIR_CLR: dir_c = wmask;
        RA_DAT_SET: dat_s = wmask;
        RA_DAT_CLR: dat_c = wmask;
        RA_PU_SET: begin
          pu_s = wmask;
          pd_c = wmask;
        end
        RA_PU_CLR: pu_c = wmask;
        RA_PD_SET: begin
          pd_s = wmask;
          pu_c = wmask;
        end
        RA_PD_CLR: pd_c = wmask;
        RA_OD_SET: od_s = wmask;
        RA_OD_CLR: od_c = wmask;
        RA_SEL_LO: begin
          sl_c = '1;
          sl_s = wmask;
        end
        RA_SEL_HI: begin
          sh_c = '1;
          sh_s = wmask;
        end
        default: ;
      endcase
    end
  end

  pr_setclr_reg #(.W(NPINS), .RST_VAL('1)) u_own (
    .clk(clk), .rst(rst), .set_m(own_s), .clr_m(own_c), .q(own_q));
  pr_setclr_reg #(.W(NPINS), .RST_VAL('0)) u_dir (
    .clk(clk), .rst(rst), .set_m(dir_s), .clr_m(dir_c), .q(dir_q));
  pr_setclr_reg #(.W(NPINS), .RST_VAL('0)) u_dat (
    .clk(clk), .rst(rst), .set_m(dat_s), .clr_m(dat_c), .q(dat_q));
  pr_setclr_reg #(.W(NPINS), .RST_VAL('1)) u_pu (
    .clk(clk), .rst(rst), .set_m(pu_s), .clr_m(pu_c), .q(pu_q));
  pr_setclr_reg #(.W(NPINS), .RST_VAL('0)) u_pd (
    .clk(clk), .rst(rst), .set_m(pd_s), .clr_m(pd_c), .q(pd_q));
  pr_setclr_reg #(.W(NPINS), .RST_VAL('0)) u_od (
    .clk(clk), .rst(rst), .set_m(od_s), .clr_m(od_c), .q(od_q));
  pr_setclr_reg #(.W(NPINS), .RST_VAL('0)) u_sel_lo (
    .clk(clk), .rst(rst), .set_m(sl_s), .clr_m(sl_c), .q(sl_q));
  pr_setclr_reg #(.W(NPINS), .RST_VAL('0)) u_sel_hi (
    .clk(clk), .rst(rst), .set_m(sh_s), .clr_m(sh_c), .q(sh_q));

  pr_level_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(lvl_q));

  pr_route_mux #(.N(NPINS), .NF(NFUNC), .SW(SEL_W)) u_mux (
    .clk(clk), .rst(rst),
    .own(own_q), .dir(dir_q), .dat(dat_q), .od(od_q),
    .pu(pu_q), .pd(pd_q), .sel_lo(sl_q), .sel_hi(sh_q),
    .pdo(periph_do), .poe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd));

  pr_bus_read #(.N(NPINS), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr),
    .own(own_q), .dir(dir_q), .dat(dat_q), .lvl(lvl_q),
    .pu(pu_q), .pd(pd_q), .od(od_q), .sel_lo(sl_q), .sel_hi(sh_q),
    .rdata(bus_rdata));
endmodule

// File: rtl/pr_checker.sv
module pr_checker
  import pr_pkg::*;
#(
  parameter int N  = 32,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [N-1:0]      own_q,
  input logic [N-1:0]      dir_q,
  input logic [N-1:0]      dat_q,
  input logic [N-1:0]      pu_q,
  input logic [N-1:0]      pd_q,
  input logic [N-1:0]      od_q,
  input logic [N-1:0]      pad_out,
  input logic [N-1:0]      pad_pu,
  input logic [N-1:0]      pad_pd
);
  logic [N-1:0] m;
  assign m = bus_wdata[N-1:0];

  p_own_set_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_OWN_SET) |=> ((own_q & $past(m)) == $past(m)));

  p_dir_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_DIR_CLR) |=> ((dir_q & $past(m)) == '0));

  p_dat_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_DAT_SET) |=>
      ((dat_q & ~$past(m)) == ($past(dat_q) & ~$past(m))));

  p_pull_state_r7: assert property (@(posedge clk) disable iff (rst)
    ((pu_q & pd_q) == '0));

  p_pull_pad_r7: assert property (@(posedge clk) disable iff (rst)
    ((pad_pu & pad_pd) == '0));

  p_od_low_r8: assert property (@(posedge clk) disable iff (rst)
    ((pad_out & $past(od_q)) == '0));

  p_ro_own_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_OWN_STAT) |=> $stable(own_q));
endmodule

bind pin_route_ctrl pr_checker #(.N(NPINS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .own_q(own_q), .dir_q(dir_q), .dat_q(dat_q),
  .pu_q(pu_q), .pd_q(pd_q), .od_q(od_q), .pad_out(pad_out),
  .pad_pu(pad_pu), .pad_pd(pad_pd));

// File: tb/sim_pin_route_ctrl.sv
`timescale 1ns/1ps
module sim_pin_route_ctrl;
  import pr_pkg::*;
  localparam int N = 32;
  localparam int DW = 32;

  logic clk = 0;
  logic rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [REG_AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [NFUNC*N-1:0] periph_do = '0, periph_oe = '0;
  logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd;

  always #5 clk = ~clk;

  pin_route_ctrl #(.NPINS(N), .DW(DW)) u0 (.*);

  int n_tests = 0, n_fail = 0;

  // reference model
  logic [N-1:0] m_own = '1, m_dir = '0, m_dat = '0, m_pu = '1;
  logic [N-1:0] m_pd = '0, m_od = '0, m_sl = '0, m_sh = '0;

  // scoreboard for reads
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic rd_q = 0;
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [REG_AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    case (a)
      RA_OWN_SET: m_own |= d;
      RA_OWN_CLR: m_own &= ~d;
      RA_DIR_SET: m_dir |= d;
      RA_DIR_CLR: m_dir &= ~d;
      RA_DAT_SET: m_dat |= d;
      RA_DAT_CLR: m_dat &= ~d;
      RA_PU_SET: begin m_pu |= d; m_pd &= ~d; end
      RA_PU_CLR: m_pu &= ~d;
      RA_PD_SET: begin m_pd |= d; m_pu &= ~d; end
      RA_PD_CLR: m_pd &= ~d;
      RA_OD_SET: m_od |= d;
      RA_OD_CLR: m_od &= ~d;
      RA_SEL_LO: m_sl = d;
      RA_SEL_HI: m_sh = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic chk(input string t, input logic [N-1:0] act, input logic [N-1:0] e);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic chk_pads(input string t);
    logic [N-1:0] eo, ee;
    for (int i = 0; i < N; i++) begin
      logic sd, so;
      int c;
      c = {m_sh[i], m_sl[i]};
      sd = m_own[i] ? m_dat[i] : periph_do[c*N+i];
      so = m_own[i] ? m_dir[i] : periph_oe[c*N+i];
      eo[i] = m_od[i] ? 1'b0 : sd;
      ee[i] = m_od[i] ? (so & ~sd) : so;
    end
    chk({t, " pad_out"}, pad_out, eo);
    chk({t, " pad_oe"}, pad_oe, ee);
    chk({t, " pad_pu"}, pad_pu, m_pu);
    chk({t, " pad_pd"}, pad_pd, m_pd);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(10 * 50000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(RA_OWN_STAT, 32'hFFFF_FFFF, "R1 owner");
    rd(RA_DIR_STAT, 0, "R1 dir");
    rd(RA_DAT_STAT, 0, "R1 dat");
    rd(RA_PU_STAT, 32'hFFFF_FFFF, "R1 pu");
    rd(RA_PD_STAT, 0, "R1 pd");
    rd(RA_OD_STAT, 0, "R1 od");
    rd(RA_SEL_LO, 0, "R1 sel lo");
    rd(RA_SEL_HI, 0, "R1 sel hi");
    chk_pads("R1");

    // R10 latency: state next cycle, pad one clock later
    wr(RA_DAT_SET, 32'h1);
    chk("R10 pad not yet", pad_out, 32'h0);
    rd(RA_DAT_STAT, 32'h1, "R10 read after write");
    chk_pads("R10 pad after");

    // R4 direction
    wr(RA_DIR_SET, 32'hFF);
    wr(RA_DIR_CLR, 32'h0F);
    rd(RA_DIR_STAT, 32'hF0, "R4 dir");
    chk_pads("R4");

    // R5 data set/clear, zero bits unchanged
    wr(RA_DAT_SET, 32'hA0);
    wr(RA_DAT_CLR, 32'h21);
    rd(RA_DAT_STAT, 32'h80, "R5 dat");
    chk_pads("R5");

    // R2 ownership, R3 function select
    wr(RA_OWN_CLR, 32'h0F00);
    rd(RA_OWN_STAT, 32'hFFFF_F0FF, "R2 owner");
    wr(RA_SEL_LO, 32'h0A00);
    wr(RA_SEL_HI, 32'h0C00);
    rd(RA_SEL_LO, 32'h0A00, "R3 sel lo");
    rd(RA_SEL_HI, 32'h0C00, "R3 sel hi");
    periph_do = {32'h0000_0800, 32'h0000_0400, 32'h0000_0200, 32'h0000_0100};
    periph_oe = {32'h0000_0800, 32'h0000_0400, 32'h0000_0200, 32'h0000_0100};
    settle();
    settle();
    chk("R3 pins 8-11 driven", pad_out[11:8], 4'hF);
    chk_pads("R3");
    wr(RA_OWN_SET, 32'h0100);
    rd(RA_OWN_STAT, 32'hFFFF_F1FF, "R2 owner back");
    settle();
    chk_pads("R2");

    // R6 level readback
    pad_in = 32'h1234_5678;
    repeat (3) settle();
    rd(RA_LEVEL, 32'h1234_5678, "R6 level");
    pad_in = 32'hFFFF_0000;
    repeat (3) settle();
    rd(RA_LEVEL, 32'hFFFF_0000, "R6 level 2");

    // R7 pull exclusivity
    wr(RA_PD_SET, 32'h3);
    rd(RA_PD_STAT, 32'h3, "R7 pd");
    rd(RA_PU_STAT, 32'hFFFF_FFFC, "R7 pu");
    chk_pads("R7 a");
    wr(RA_PU_SET, 32'h1);
    rd(RA_PU_STAT, 32'hFFFF_FFFD, "R7 pu back");
    rd(RA_PD_STAT, 32'h2, "R7 pd cleared");
    chk_pads("R7 b");

    // R8 open drain on I/O and peripheral pins
    wr(RA_OD_SET, 32'h2C0);
    rd(RA_OD_STAT, 32'h2C0, "R8 od");
    settle();
    chk("R8 od oe", pad_oe[9:6], 4'b0001);
    chk_pads("R8");

    // R9 read-only and unmapped writes
    wr(RA_DIR_STAT, 32'hFFFF_FFFF);
    wr(RA_OWN_STAT, 32'h0);
    wr(RA_LEVEL, 32'h0);
    wr(RA_PD_STAT, 32'hFFFF_FFFF);
    wr(5'd25, 32'hFFFF_FFFF);
    rd(RA_DIR_STAT, 32'hF0, "R9 dir unchanged");
    rd(RA_OWN_STAT, 32'hFFFF_F1FF, "R9 owner unchanged");
    rd(RA_PD_STAT, 32'h2, "R9 pd unchanged");
    rd(5'd25, 32'h0, "R9 unmapped read");
    settle();
    chk_pads("R9");

    repeat (3) settle();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule